// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel

This block is one DMA channel that takes all of its work from control blocks kept in memory. Software writes the byte address of a first block into the block-address register and then sets the run bit in the status register. The channel reads the six meaningful words of that 32-byte block over a simple request/acknowledge memory port. Those words are the info word, the source address, the destination address, the byte length, the stride and the next-block pointer. The channel then copies the data one 32-bit word at a time, reading the source and writing the destination. When the block ends it moves on to the block named by the next pointer. A next pointer of zero ends the chain. The block-address register then reads zero, which is the only reliable sign that the channel is idle.

Any side of the copy can be paced by a peripheral request line, chosen from the `dreq` bus by a 5-bit select field in the info word. Software controls the channel through the status register. Writing 0 to the run bit pauses the channel. Writing 1 to bit 30 abandons the current block. Writing 1 to bit 31 resets the channel at once. Each finished block sets an end flag, and can also raise the interrupt flag and the `irq` output.

The sequencer has five named states. It leaves **IDLE** for **FETCH** when the run bit is set and the block address is non-zero. It leaves **FETCH** once the sixth field has been read, going to **READ**, or to **DONE** if the length is zero. It leaves **READ** for **WRITE** after the source word is read or skipped. It leaves **WRITE** for **READ** while bytes remain, and for **DONE** when the length reaches zero. An abort moves **READ** or **WRITE** to **DONE** at the next access boundary. **DONE** always returns to **IDLE** and loads the next pointer.

Top module: `dma_chan`

## Requirements
- R1: The register map is laid out by byte offset:
  - 0x00 is status.
  - 0x04 is the block address.
  - 0x08 through 0x1C hold, in order, the working info, source, destination, remaining length, stride and next pointer.
  - 0x20 is debug.
  - Status bits: bit 0 run, bit 1 end, bit 2 interrupt pending, bit 3 level of the selected request line, bit 4 paused (the inverse of run), bit 5 held by request pacing, bit 6 write outstanding. Bits 8, 30 and 31 read 0.
  - After reset, status reads 0x10 when the selected line is low, the block address and debug read 0, and `irq` is low.
- R2: A write to offset 0x04 stores the address with bits 4:0 forced to 0. Setting the run bit while the address is non-zero fetches the block words at address+0 through address+20, in the order info, source, destination, length, stride, next.
- R3: Each word step reads the source and then writes that data to the destination. The source advances by 4 after each step when info bit 8 is set, and the destination advances by 4 when info bit 4 is set. The length drops by 4 per step, saturating at 0, and the block ends when it reaches 0. A memory request is held, with a stable address, until it is acknowledged.
- R4: With info bit 11 set, the channel issues no source read and uses zero as the data. With info bit 7 set, it issues no destination write.
- R5: After a block ends, the next pointer, with bits 4:0 forced to 0, becomes the block address and the channel follows it. If the next pointer is zero, the block address reads 0 and the run bit clears.
- R6: Info bits 20:16 select one `dreq` line. With info bit 10 (source) or bit 6 (destination) set, each access on that side waits for the selected line to be high. While waiting, status bit 5 reads 1.
- R7: Every block end sets status bit 1. If info bit 0 is set, it also sets status bit 2 and `irq`, which stay high until a status write with bit 2 set clears them. A status write with bit 1 set clears the end flag.
- R8: A status write of 0x5 clears the interrupt and keeps the run bit set, so a chain that loops back to itself keeps running and interrupts again.
- R9: A status write with bit 0 clear stops new memory requests, while a request already in flight still completes. Status bit 4 then reads 1. A later write with bit 0 set resumes the block where it stopped.
- R10: A status write with bit 30 set abandons the rest of the current block at the next access boundary. The channel then continues with that block's next pointer.
- R11: A status write with bit 31 set returns the channel to its reset state on the next cycle and drops any pending memory request.
- R12: When the block length is limited (parameter `LITE` = 1), a loaded length above 65532 is clipped to 65532, and debug bit 28 reads 1. With `LITE` = 0, the length is not clipped and debug bit 28 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from `csr_addr`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data is valid with it |
| mem_rdata | input | 32 | Memory read data |
| dreq | input | NREQ | Peripheral request lines |
| irq | output | 1 | Interrupt, high while status bit 2 is set |

## Verification
The assertions watch the properties that must hold on every cycle:
- A pending memory request stays held with a stable address until acknowledged.
- A paced write starts only after the selected request line was high.
- No request starts while the channel is paused.
- The start transition out of IDLE happens when it should.
- A zero next pointer leaves the block address at zero.
- The self-clearing reset drops everything on the following cycle.
- `irq` rises only from a block end with interrupts enabled.

Only the bench scenarios can show the data that lands in memory: the increment, fixed-address and skip combinations, chains of blocks, and an abort that leaves the first destination untouched. The same holds for interrupt clearing on a looping chain, a paused transfer that resumes, and length clipping in the limited variant.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    // info word bit positions (decoded by the sequencer)
    localparam int IB_IRQ_EN   = 0;
    localparam int IB_DST_INC  = 4;
    localparam int IB_DST_PACE = 6;
    localparam int IB_DST_SKIP = 7;
    localparam int IB_SRC_INC  = 8;
    localparam int IB_SRC_PACE = 10;
    localparam int IB_SRC_SKIP = 11;
    localparam int IB_SEL_LO   = 16;
    localparam int SEL_W       = 5;

    // status bit positions
    localparam int SB_RUN    = 0;
    localparam int SB_END    = 1;
    localparam int SB_INT    = 2;
    localparam int SB_LEVEL  = 3;
    localparam int SB_PAUSED = 4;
    localparam int SB_HELD   = 5;
    localparam int SB_WROUT  = 6;
    localparam int SB_ABORT  = 30;
    localparam int SB_RESET  = 31;

    localparam int DBG_LIMITED = 28;

    // register byte offsets
    localparam logic [5:0] OFS_STATUS = 6'h00;
    localparam logic [5:0] OFS_CBADDR = 6'h04;
    localparam logic [5:0] OFS_INFO   = 6'h08;
    localparam logic [5:0] OFS_SRC    = 6'h0C;
    localparam logic [5:0] OFS_DST    = 6'h10;
    localparam logic [5:0] OFS_LEN    = 6'h14;
    localparam logic [5:0] OFS_STRIDE = 6'h18;
    localparam logic [5:0] OFS_NEXT   = 6'h1C;
    localparam logic [5:0] OFS_DEBUG  = 6'h20;

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
    parameter int NREQ = 32,
    parameter int SELW = 5
) (
    input  logic [NREQ-1:0] req_in,
    input  logic [SELW-1:0] sel,
    output logic            req_out
);
    localparam int NPAD = 2 ** SELW;

    logic [NPAD-1:0] padded;

    generate
        if (NREQ >= NPAD) begin : g_wide
            assign padded = req_in[NPAD-1:0];
        end else begin : g_narrow
            assign padded = {{(NPAD-NREQ){1'b0}}, req_in};
        end
    endgenerate

    assign req_out = padded[sel];
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int DW           = 32,
    parameter bit LITE         = 1'b0,
    parameter int LITE_MAX_LEN = 65532,
    parameter int CB_BYTES     = 32,
    parameter int FIELDS       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [5:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          req_ok,
    output seq_state_e    state,
    output logic          run,
    output logic          end_flag,
    output logic          int_flag,
    output logic          held,
    output logic          wr_out,
    output logic          soft_rst,
    output logic [DW-1:0] cb_addr,
    output logic [DW-1:0] info,
    output logic [DW-1:0] src,
    output logic [DW-1:0] dst,
    output logic [DW-1:0] len,
    output logic [DW-1:0] stride,
    output logic [DW-1:0] next_ptr
);
    localparam int BPW   = DW / 8;
    localparam int AB    = $clog2(CB_BYTES);
    localparam int FIW   = $clog2(FIELDS);
    localparam int WSH   = $clog2(BPW);

    seq_state_e state_q, state_d;
    logic [FIW-1:0] fidx_q;
    logic           req_q, abort_q;
    logic [DW-1:0]  data_q, len_in, len_dec;

    wire src_skip = info[IB_SRC_SKIP];
    wire dst_skip = info[IB_DST_SKIP];
    wire src_wait = info[IB_SRC_PACE] && !req_ok;
    wire dst_wait = info[IB_DST_PACE] && !req_ok;
    wire st_wr    = csr_we && csr_addr == OFS_STATUS;
    wire acked    = req_q && mem_ack;
    wire rd_skip  = (state_q == ST_READ)  && !req_q && !abort_q && run && src_skip;
    wire wr_skip  = (state_q == ST_WRITE) && !req_q && !abort_q && run && dst_skip;
    wire go_fetch = (state_q == ST_FETCH) && !req_q && run;
    wire go_rd    = (state_q == ST_READ)  && !req_q && !abort_q && run && !src_skip && !src_wait;
    wire go_wr    = (state_q == ST_WRITE) && !req_q && !abort_q && run && !dst_skip && !dst_wait;

    assign soft_rst = st_wr && csr_wdata[SB_RESET];
    assign len_dec  = (len <= DW'(BPW)) ? '0 : len - DW'(BPW);

    generate
        if (LITE) begin : g_clip
            assign len_in = (mem_rdata > DW'(LITE_MAX_LEN)) ? DW'(LITE_MAX_LEN) : mem_rdata;
        end else begin : g_full
            assign len_in = mem_rdata;
        end
    endgenerate

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run && cb_addr != '0) state_d = ST_FETCH;
            ST_FETCH: if (acked && fidx_q == FIW'(FIELDS-1))
                          state_d = (len == '0) ? ST_DONE : ST_READ;
            ST_READ:  if (!req_q && abort_q)     state_d = ST_DONE;
                      else if (rd_skip || acked) state_d = ST_WRITE;
            ST_WRITE: if (!req_q && abort_q)     state_d = ST_DONE;
                      else if (wr_skip || acked) state_d = (len_dec == '0) ? ST_DONE : ST_READ;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (soft_rst) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    // memory port outputs
    always_comb begin
        unique case (state_q)
            ST_FETCH: mem_addr = cb_addr + (DW'(fidx_q) << WSH);
            ST_READ:  mem_addr = src;
            ST_WRITE: mem_addr = dst;
            default:  mem_addr = '0;
        endcase
    end
    assign mem_req   = req_q;
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_wdata = data_q;
    assign state     = state_q;
    assign wr_out    = req_q && (state_q == ST_WRITE);
    assign held      = ((state_q == ST_READ)  && !req_q && !src_skip && src_wait)
                    || ((state_q == ST_WRITE) && !req_q && !dst_skip && dst_wait);

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_rst) begin
            {run, end_flag, int_flag, req_q, abort_q} <= '0;
            fidx_q  <= '0;
            {cb_addr, info, src, dst, len, stride, next_ptr, data_q} <= '0;
        end else begin
            if (st_wr) begin
                run <= csr_wdata[SB_RUN];
                if (csr_wdata[SB_INT])   int_flag <= 1'b0;
                if (csr_wdata[SB_END])   end_flag <= 1'b0;
                if (csr_wdata[SB_ABORT]) abort_q  <= 1'b1;
            end
            if (csr_we && csr_addr == OFS_CBADDR && state_q == ST_IDLE)
                cb_addr <= {csr_wdata[DW-1:AB], {AB{1'b0}}};
            if (go_fetch || go_rd || go_wr) req_q <= 1'b1;
            if (acked) req_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: abort_q <= 1'b0;
                ST_FETCH: if (acked) begin
                    case (int'(fidx_q))
                        0:       info     <= mem_rdata;
                        1:       src      <= mem_rdata;
                        2:       dst      <= mem_rdata;
                        3:       len      <= len_in;
                        4:       stride   <= mem_rdata;
                        default: next_ptr <= {mem_rdata[DW-1:AB], {AB{1'b0}}};
                    endcase
                    fidx_q <= (fidx_q == FIW'(FIELDS-1)) ? '0 : fidx_q + 1'b1;
                end
                ST_READ: if (acked || rd_skip) begin
                    data_q <= rd_skip ? '0 : mem_rdata;
                    if (info[IB_SRC_INC]) src <= src + DW'(BPW);
                end
                ST_WRITE: if (acked || wr_skip) begin
                    len <= len_dec;
                    if (info[IB_DST_INC]) dst <= dst + DW'(BPW);
                end
                ST_DONE: begin
                    end_flag <= 1'b1;
                    if (info[IB_IRQ_EN]) int_flag <= 1'b1;
                    cb_addr <= next_ptr;
                    if (next_ptr == '0) run <= 1'b0;
                    abort_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_chan_pkg::*;
#(
    parameter int DW   = 32,
    parameter bit LITE = 1'b0
) (
    input  logic [5:0]    csr_addr,
    input  logic          run,
    input  logic          end_flag,
    input  logic          int_flag,
    input  logic          req_level,
    input  logic          held,
    input  logic          wr_out,
    input  logic [DW-1:0] cb_addr,
    input  logic [DW-1:0] info,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] len,
    input  logic [DW-1:0] stride,
    input  logic [DW-1:0] next_ptr,
    output logic [DW-1:0] csr_rdata
);
    logic [DW-1:0] status, debug;

    always_comb begin
        status             = '0;
        status[SB_RUN]     = run;
        status[SB_END]     = end_flag;
        status[SB_INT]     = int_flag;
        status[SB_LEVEL]   = req_level;
        status[SB_PAUSED]  = !run;
        status[SB_HELD]    = held;
        status[SB_WROUT]   = wr_out;
        debug              = '0;
        debug[DBG_LIMITED] = LITE;
    end

    always_comb begin
        unique case (csr_addr)
            OFS_STATUS: csr_rdata = status;
            OFS_CBADDR: csr_rdata = cb_addr;
            OFS_INFO:   csr_rdata = info;
            OFS_SRC:    csr_rdata = src;
            OFS_DST:    csr_rdata = dst;
            OFS_LEN:    csr_rdata = len;
            OFS_STRIDE: csr_rdata = stride;
            OFS_NEXT:   csr_rdata = next_ptr;
            OFS_DEBUG:  csr_rdata = debug;
            default:    csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int DW           = 32,
    parameter int NREQ         = 32,
    parameter bit LITE         = 1'b0,
    parameter int LITE_MAX_LEN = 65532
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [5:0]      csr_addr,
    input  logic [DW-1:0]   csr_wdata,
    output logic [DW-1:0]   csr_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [NREQ-1:0] dreq,
    output logic            irq
);
    seq_state_e    state;
    logic          run, end_flag, int_flag, held, wr_out, soft_rst, req_ok;
    logic [DW-1:0] cb_addr, info, src, dst, len, stride, next_ptr;

    dma_req_sel #(.NREQ(NREQ), .SELW(SEL_W)) u_sel (
        .req_in (dreq),
        .sel    (info[IB_SEL_LO +: SEL_W]),
        .req_out(req_ok)
    );

    dma_chan_seq #(.DW(DW), .LITE(LITE), .LITE_MAX_LEN(LITE_MAX_LEN)) u_seq (
        .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .req_ok, .state, .run, .end_flag, .int_flag, .held, .wr_out, .soft_rst,
        .cb_addr, .info, .src, .dst, .len, .stride, .next_ptr
    );

    dma_chan_csr #(.DW(DW), .LITE(LITE)) u_csr (
        .csr_addr, .run, .end_flag, .int_flag, .req_level(req_ok), .held, .wr_out,
        .cb_addr, .info, .src, .dst, .len, .stride, .next_ptr, .csr_rdata
    );

    assign irq = int_flag;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk
    import dma_chan_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          irq,
    input logic          run,
    input logic          req_ok,
    input seq_state_e    state,
    input logic [DW-1:0] cb_addr,
    input logic [DW-1:0] info,
    input logic [DW-1:0] next_ptr
);
    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !soft_rst |=> mem_req);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !soft_rst |=> $stable(mem_addr) && $stable(mem_we));

    assert_paced_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we && info[IB_DST_PACE] |-> $past(req_ok));

    assert_paused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !mem_req |=> !mem_req);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !mem_req && !irq && !run && cb_addr == '0);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state == ST_DONE && info[IB_IRQ_EN]));

    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE && run && cb_addr != '0 && !soft_rst |=> state == ST_FETCH);

    assert_chain_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DONE && next_ptr == '0 |=> cb_addr == '0 && !run);
endmodule

bind dma_chan dma_chan_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq),
    .run(run), .req_ok(req_ok), .state(state), .cb_addr(cb_addr),
    .info(info), .next_ptr(next_ptr)
);

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    // info bit values
    localparam logic [31:0] I_IRQ  = 32'h1,   I_DINC = 32'h10,  I_DPACE = 32'h40;
    localparam logic [31:0] I_DSKP = 32'h80,  I_SINC = 32'h100, I_SSKP  = 32'h800;
    localparam logic [31:0] VINFO [NV] = '{I_SINC|I_DINC|I_IRQ, I_DINC, I_SSKP|I_DINC|I_IRQ,
                                           I_SINC|I_DSKP, I_SINC};
    localparam logic [31:0] VLEN  [NV] = '{32'd16, 32'd12, 32'd8, 32'd8, 32'd12};
    localparam int SRC_W = 64, DST_W = 128;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        csr_we = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0, csr_rdata;
    logic        mem_req, mem_we, mem_ack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] dreq = '0;
    logic [31:0] mem [0:255];

    dma_chan u_dut (
        .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .dreq, .irq
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req & ~mem_ack;
            if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr[9:2]];

    // limited-length variant with a fixed block image
    logic        l_we = 1'b0;
    logic [5:0]  l_addr = '0;
    logic [31:0] l_wdata = '0, l_rdata, l_maddr, l_mwdata, l_mrdata;
    logic        l_req, l_mwe, l_ack, l_irq;
    logic [31:0] l_dreq = '0;

    dma_chan #(.LITE(1'b1)) u_lite (
        .clk, .rst_n, .csr_we(l_we), .csr_addr(l_addr), .csr_wdata(l_wdata),
        .csr_rdata(l_rdata), .mem_req(l_req), .mem_we(l_mwe), .mem_addr(l_maddr),
        .mem_wdata(l_mwdata), .mem_ack(l_ack), .mem_rdata(l_mrdata),
        .dreq(l_dreq), .irq(l_irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_ack <= 1'b0;
        else        l_ack <= l_req & ~l_ack;
    end
    always_comb begin
        case (l_maddr[4:2])
            3'd0:    l_mrdata = I_SSKP | I_DPACE | 32'h0001_0000;
            3'd2:    l_mrdata = 32'h200;
            3'd3:    l_mrdata = 32'h0001_0000;
            default: l_mrdata = '0;
        endcase
    end

    int total = 0, fails = 0, wrout_cnt = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [5:0] a, output logic [31:0] d);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_idle(input int maxc);
        logic [31:0] s;
        wrout_cnt = 0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            csr_rd(6'h00, s);
            if (s[6]) wrout_cnt++;
            if (!s[0]) break;
        end
    endtask

    task automatic put_cb(input int w, input logic [31:0] inf, sa, da, ln, nx);
        mem[w] = inf; mem[w+1] = sa; mem[w+2] = da; mem[w+3] = ln;
        mem[w+4] = 32'h0; mem[w+5] = nx; mem[w+6] = 32'h0; mem[w+7] = 32'h0;
    endtask

    task automatic fill_dst();
        for (int i = 0; i < 8; i++) mem[DST_W+i] = 32'h5E00_0000 + i;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_d [8];
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) mem[SRC_W+i] = 32'hA000_0000 + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        csr_rd(6'h00, r); check("R1 status after reset", r, 32'h10);
        csr_rd(6'h04, r); check("R1 block address after reset", r, 32'h0);
        csr_rd(6'h20, r); check("R1 debug full-length variant", r, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // table of single-block transfers
        for (int v = 0; v < NV; v++) begin
            int n;
            n = int'(VLEN[v]) / 4;
            fill_dst();
            for (int i = 0; i < 8; i++) exp_d[i] = 32'h5E00_0000 + i;
            for (int k = 0; k < n; k++) begin
                logic [31:0] val;
                val = VINFO[v][11] ? 32'h0 : 32'hA000_0000 + (VINFO[v][8] ? k : 0);
                if (!VINFO[v][7]) exp_d[VINFO[v][4] ? k : 0] = val;
            end
            put_cb(8, VINFO[v], 32'h100, 32'h200, VLEN[v], 32'h0);
            csr_wr(6'h04, 32'h20);
            csr_wr(6'h00, 32'h1);
            wait_idle(400);
            for (int i = 0; i < 8; i++) check("R3/R4 destination word", mem[DST_W+i], exp_d[i]);
            check("R6 write-outstanding cycles", wrout_cnt, VINFO[v][7] ? 0 : 2*n);
            csr_rd(6'h0C, r); check("R3 final source", r, 32'h100 + (VINFO[v][8] ? VLEN[v] : 0));
            csr_rd(6'h10, r); check("R3 final destination", r, 32'h200 + (VINFO[v][4] ? VLEN[v] : 0));
            csr_rd(6'h08, r); check("R2 info readback", r, VINFO[v]);
            csr_rd(6'h14, r); check("R3 length counted to zero", r, 32'h0);
            csr_rd(6'h04, r); check("R5 idle block address", r, 32'h0);
            check("R7 irq follows enable", {31'b0, irq}, {31'b0, VINFO[v][0]});
            csr_rd(6'h00, r); check("R7 end flag set", {31'b0, r[1]}, 32'h1);
            csr_wr(6'h00, 32'h6);
            csr_rd(6'h00, r); check("R7 flags cleared", r & 32'h7, 32'h0);
        end

        // R2 alignment and R5 chain with misaligned next pointer
        fill_dst();
        put_cb(8,  I_SINC|I_DINC, 32'h100, 32'h200, 32'd8, 32'h47);
        put_cb(16, I_SINC|I_DINC|I_IRQ, 32'h110, 32'h210, 32'd4, 32'h0);
        csr_wr(6'h04, 32'h3F);
        csr_rd(6'h04, r); check("R2 address low bits forced to zero", r, 32'h20);
        csr_wr(6'h00, 32'h1);
        wait_idle(400);
        check("R5 chain block0 word0", mem[DST_W],   32'hA000_0000);
        check("R5 chain block0 word1", mem[DST_W+1], 32'hA000_0001);
        check("R5 chain block1 word",  mem[DST_W+4], 32'hA000_0004);
        check("R5 chain untouched gap", mem[DST_W+2], 32'h5E00_0002);
        check("R7 irq at chain end", {31'b0, irq}, 32'h1);
        csr_wr(6'h00, 32'h6);

        // R6 pacing, R9 pause/resume
        fill_dst();
        put_cb(8, I_SINC|I_DINC|I_DPACE|(32'd5 << 16), 32'h100, 32'h200, 32'd8, 32'h0);
        csr_wr(6'h04, 32'h20);
        csr_wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        csr_rd(6'h00, r);
        check("R6 held while request low", {31'b0, r[5]}, 32'h1);
        check("R6 level bit low", {31'b0, r[3]}, 32'h0);
        check("R6 no write while held", mem[DST_W], 32'h5E00_0000);
        csr_wr(6'h00, 32'h0);
        dreq[5] = 1'b1;
        csr_rd(6'h00, r);
        check("R9 paused bit", {31'b0, r[4]}, 32'h1);
        check("R6 level bit high", {31'b0, r[3]}, 32'h1);
        repeat (20) @(negedge clk);
        check("R9 no write while paused", mem[DST_W], 32'h5E00_0000);
        csr_wr(6'h00, 32'h1);
        wait_idle(400);
        check("R9 resumed word0", mem[DST_W],   32'hA000_0000);
        check("R9 resumed word1", mem[DST_W+1], 32'hA000_0001);
        csr_wr(6'h00, 32'h6);
        dreq[5] = 1'b0;

        // R10 abort moves to next block
        fill_dst();
        put_cb(8,  I_SINC|I_DINC|I_DPACE|(32'd5 << 16), 32'h100, 32'h200, 32'd8, 32'h40);
        put_cb(16, I_SINC|I_DINC|I_IRQ, 32'h110, 32'h210, 32'd4, 32'h0);
        csr_wr(6'h04, 32'h20);
        csr_wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        csr_wr(6'h00, 32'h4000_0001);
        wait_idle(400);
        check("R10 aborted block not written", mem[DST_W], 32'h5E00_0000);
        check("R10 next block ran", mem[DST_W+4], 32'hA000_0004);
        csr_rd(6'h04, r); check("R10 chain ended", r, 32'h0);
        check("R10 irq from next block", {31'b0, irq}, 32'h1);
        csr_wr(6'h00, 32'h6);

        // R8 looping chain, R11 soft reset
        put_cb(8, I_SINC|I_DINC|I_IRQ, 32'h100, 32'h200, 32'd4, 32'h20);
        csr_wr(6'h04, 32'h20);
        csr_wr(6'h00, 32'h1);
        for (int c = 0; c < 60 && !irq; c++) @(negedge clk);
        check("R8 loop first interrupt", {31'b0, irq}, 32'h1);
        csr_wr(6'h00, 32'h5);
        csr_rd(6'h00, r);
        check("R8 interrupt cleared", {31'b0, irq}, 32'h0);
        check("R8 still running", {31'b0, r[0]}, 32'h1);
        for (int c = 0; c < 60 && !irq; c++) @(negedge clk);
        check("R8 loop interrupts again", {31'b0, irq}, 32'h1);
        csr_wr(6'h00, 32'h8000_0000);
        csr_rd(6'h04, r); check("R11 block address cleared", r, 32'h0);
        csr_rd(6'h00, r); check("R11 status reset", r, 32'h10);
        check("R11 irq cleared", {31'b0, irq}, 32'h0);
        check("R11 request dropped", {31'b0, mem_req}, 32'h0);

        // R12 limited-length variant
        @(negedge clk); l_we = 1'b1; l_addr = 6'h04; l_wdata = 32'h40;
        @(negedge clk); l_addr = 6'h00; l_wdata = 32'h1;
        @(negedge clk); l_we = 1'b0;
        repeat (40) @(negedge clk);
        l_addr = 6'h14; #1 check("R12 length clipped", l_rdata, 32'd65532);
        l_addr = 6'h20; #1 check("R12 debug limited bit", l_rdata, 32'h1000_0000);
        @(negedge clk); l_we = 1'b1; l_addr = 6'h00; l_wdata = 32'h8000_0000;
        @(negedge clk); l_we = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule